// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block is the transmit half of an asynchronous serial port. A CPU writes a data word into a one-word holding register. A shift register behind it sends the word out as a serial frame. Each frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one, one-and-a-half or two high stop bits. Every bit lasts 16 pulses of the 16x bit-clock enable input. The baud-rate divider that produces the enable is outside the block.

The word moves from the holding register into the shifter at the tick that starts the start bit. From then on the holding register is free again, so software can keep one word queued behind the frame on the line and frames follow each other with no idle gap. Two status flags show which stage is free: holding-empty and shifter-empty. A one-cycle event strobe marks each handoff and can drive an interrupt request. The line settings are taken at the handoff, so a frame in flight is never changed by a later write.

Top module: `serial_tx`

## Requirements
- R1: `lineCtl[1:0]` sets the word length: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits. Data bits go out least significant bit first, and bits of `wrData` above the selected length never reach the line.
- R2: With `lineCtl[3]`=1 a parity bit follows the last data bit. With `lineCtl[4]`=1 the parity is even: the data ones plus the parity bit give an even count. With `lineCtl[4]`=0 the parity is odd. With `lineCtl[3]`=0 the stop bits follow the data directly.
- R3: A cycle with `wrEn` high loads the holding register and drives `holdEmpty` low in the next cycle.
- R4: With a word held and the shifter idle, the next tick starts the start bit. In the cycle after that tick `txOut` is low, `holdEmpty` is high, `shiftEmpty` is low and `emptyEvt` is high for exactly one cycle.
- R5: A word written while a frame is on the line keeps `holdEmpty` and `shiftEmpty` low until that frame's last stop tick. That tick starts the next start bit, with no idle gap between the frames.
- R6: When the last stop tick passes and no word is held, `shiftEmpty` goes high. `shiftEmpty` stays high while the line is idle.
- R7: Reset (`rst` high, synchronous) sets `holdEmpty` and `shiftEmpty`, drives `txOut` high and clears `emptyEvt`.
- R8: The start bit and each data and parity bit last 16 ticks. The stop time is 16 ticks when `lineCtl[2]`=0. It is 24 ticks when `lineCtl[2]`=1 and the length is 5 bits, and 32 ticks when `lineCtl[2]`=1 with any other length.
- R9: Line settings are sampled at the handoff. Changing `lineCtl` after the handoff does not change the frame on the line.
- R10: `txOut` changes only at clock edges where `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | 16x bit-clock enable, one cycle per tick |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Word to send |
| lineCtl | input | 5 | [1:0] length, [2] long stop, [3] parity on, [4] even parity |
| txOut | output | 1 | Serial line, high when idle |
| holdEmpty | output | 1 | Holding register free |
| shiftEmpty | output | 1 | Shifter idle, nothing on the line |
| emptyEvt | output | 1 | One-cycle pulse at each holding-to-shifter handoff |

## Verification
The bench decodes the line at mid-bit, so a design that shifted the wrong way or leaked upper bits into a short word would show wrong data or wrong parity. It measures, in ticks, the time from one handoff to the next and from a handoff to `shiftEmpty` rising. A stop time off by even one tick, including the 1.5-stop case that exists only for 5-bit words, therefore shows up as a count mismatch or a gap between back-to-back frames. In back-to-back runs the bench watches both flags, and a design that let `holdEmpty` rise early or dropped `shiftEmpty` between frames would be reported. It also changes `lineCtl` right after each handoff, which exposes a design that reads the settings live rather than latching them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_e;

  // What the datapath puts on the line
  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } lineSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e sel;
  } dpCmd_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int TICKS  = 16,
  parameter int WORD_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [4:0] lineCtl,
  output dpCmd_t     cmd,
  output logic       holdEmpty,
  output logic       shiftEmpty,
  output logic       emptyEvt
);

  localparam int CNT_W    = $clog2(2 * TICKS);
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int WORD_MIN = WORD_W - 3;
  localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0] STOP1_LAST  = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(TICKS + TICKS / 2 - 1);
  localparam logic [CNT_W-1:0] STOP2_LAST  = CNT_W'(2 * TICKS - 1);

  txState_e          state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [IDX_W-1:0]  bitIdx, idxNxt;
  logic [IDX_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  stopLast;
  logic              parOn;
  logic              holdFull;
  logic              doLoad, doShift;
  logic [CNT_W-1:0]  stopPick;

  // Stop time chosen from the settings at handoff
  always_comb begin
    if (!lineCtl[2])               stopPick = STOP1_LAST;
    else if (lineCtl[1:0] == 2'b00) stopPick = STOP15_LAST;
    else                           stopPick = STOP2_LAST;
  end

  // Next-state logic for the frame sequencer
  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    idxNxt   = bitIdx;
    doLoad   = 1'b0;
    doShift  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (tick && holdFull) begin
          doLoad   = 1'b1;
          stateNxt = ST_START;
          cntNxt   = '0;
        end
      end
      ST_START, ST_DATA, ST_PAR: begin
        if (tick) begin
          if (cnt == BIT_LAST) begin
            cntNxt = '0;
            if (state == ST_START) begin
              stateNxt = ST_DATA;
              idxNxt   = '0;
            end else if (state == ST_DATA) begin
              doShift = 1'b1;
              if (bitIdx == lastIdx) stateNxt = parOn ? ST_PAR : ST_STOP;
              else                   idxNxt   = bitIdx + 1'b1;
            end else begin
              stateNxt = ST_STOP;
            end
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (cnt == stopLast) begin
            cntNxt = '0;
            if (holdFull) begin
              doLoad   = 1'b1;
              stateNxt = ST_START;
            end else begin
              stateNxt = ST_IDLE;
            end
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      lastIdx  <= IDX_W'(WORD_W - 1);
      stopLast <= STOP1_LAST;
      parOn    <= 1'b0;
      holdFull <= 1'b0;
      emptyEvt <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      bitIdx   <= idxNxt;
      emptyEvt <= doLoad;
      if (wrEn)        holdFull <= 1'b1;
      else if (doLoad) holdFull <= 1'b0;
      if (doLoad) begin
        lastIdx  <= IDX_W'(WORD_MIN - 1) + IDX_W'(lineCtl[1:0]);
        stopLast <= stopPick;
        parOn    <= lineCtl[3];
      end
    end
  end

  always_comb begin
    cmd.load  = doLoad;
    cmd.shift = doShift;
    unique case (state)
      ST_START: cmd.sel = LINE_SPACE;
      ST_DATA:  cmd.sel = LINE_DATA;
      ST_PAR:   cmd.sel = LINE_PAR;
      default:  cmd.sel = LINE_MARK;
    endcase
  end

  assign holdEmpty  = !holdFull;
  assign shiftEmpty = (state == ST_IDLE);

  // R3
  hold_low_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !holdEmpty);

  // R4
  evt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    emptyEvt |-> (holdEmpty && !shiftEmpty));

  // R4
  hold_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(holdEmpty) |-> emptyEvt);

  // R4
  shift_fall_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(shiftEmpty) |-> emptyEvt);

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [4:0]        lineCtl,
  input  dpCmd_t            cmd,
  output logic              txOut
);

  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] lenMask;
  logic [WORD_W-1:0] maskedWord;
  logic              parBit;

  // Keep only the selected number of low bits
  always_comb begin
    lenMask    = {WORD_W{1'b1}} >> (2'd3 - lineCtl[1:0]);
    maskedWord = holdReg & lenMask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (wrEn) holdReg <= wrData;
      if (cmd.load) begin
        shiftReg <= maskedWord;
        parBit   <= lineCtl[4] ? (^maskedWord) : (~^maskedWord);
      end else if (cmd.shift) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  always_comb begin
    unique case (cmd.sel)
      LINE_SPACE: txOut = 1'b0;
      LINE_DATA:  txOut = shiftReg[0];
      LINE_PAR:   txOut = parBit;
      default:    txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import sertx_pkg::*;
#(
  parameter int TICKS  = 16,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [4:0]        lineCtl,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              shiftEmpty,
  output logic              emptyEvt
);

  dpCmd_t cmd;

  sertx_ctrl #(.TICKS(TICKS), .WORD_W(WORD_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .wrEn       (wrEn),
    .lineCtl    (lineCtl),
    .cmd        (cmd),
    .holdEmpty  (holdEmpty),
    .shiftEmpty (shiftEmpty),
    .emptyEvt   (emptyEvt)
  );

  sertx_datapath #(.WORD_W(WORD_W)) uPath (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .lineCtl (lineCtl),
    .cmd     (cmd),
    .txOut   (txOut)
  );

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (holdEmpty && shiftEmpty && txOut && !emptyEvt));

  // R4
  start_on_evt_chk: assert property (@(posedge clk) disable iff (rst)
    emptyEvt |-> !txOut);

  // R6
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shiftEmpty) |-> txOut);

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick16 |=> $stable(txOut));

endmodule

// File: tb/sim_serial_tx.sv
module sim_serial_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [4:0] lineCtl = '0;
  logic       txOut, holdEmpty, shiftEmpty, emptyEvt;

  int   testsRun = 0;
  int   testsFailed = 0;
  int   tickIdx = 0;
  int   cycles = 0;
  int   divCnt = 0;
  int   r10Bad = 0;
  logic tickHit = 1'b0;
  logic lastTx = 1'b1;

  typedef struct {
    logic [7:0] data;
    logic [4:0] ctl;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  serial_tx u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .wrEn(wrEn), .wrData(wrData),
    .lineCtl(lineCtl), .txOut(txOut), .holdEmpty(holdEmpty),
    .shiftEmpty(shiftEmpty), .emptyEvt(emptyEvt)
  );

  // One tick every four cycles, driven away from the sampling edge
  always @(negedge clk) begin
    divCnt <= (divCnt == 3) ? 0 : divCnt + 1;
    tick16 <= (divCnt == 3);
  end

  always @(posedge clk) begin
    tickHit <= tick16;
    if (tick16) tickIdx <= tickIdx + 1;
    cycles <= cycles + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wordLen(input logic [4:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic int frameTicks(input logic [4:0] c);
    int stopT;
    if (!c[2])              stopT = 16;
    else if (c[1:0] == 2'b00) stopT = 24;
    else                    stopT = 32;
    return 16 * (1 + wordLen(c) + int'(c[3])) + stopT;
  endfunction

  function automatic logic [7:0] maskWord(input logic [7:0] d, input logic [4:0] c);
    return d & (8'hFF >> (3 - int'(c[1:0])));
  endfunction

  // R10: line may only move after a tick edge
  always @(negedge clk) begin
    if (!rst && !tickHit && (txOut !== lastTx)) r10Bad++;
    lastTx = txOut;
  end

  task automatic nextTick();
    do @(negedge clk); while (!tickHit);
  endtask

  // Monitor: reference sampler decoding each frame at mid-bit
  task automatic runFrame();
    item_t      it;
    int         len, par, ft, bitNo;
    logic [7:0] rxData;
    logic       rxPar, startBit, stopAll;
    logic [7:0] expData;
    logic       expPar;
    if (sbq.size() == 0) begin
      check(1'b0, "R1 unexpected frame", 1, 0);
      return;
    end
    it = sbq.pop_front();
    len = wordLen(it.ctl);
    par = int'(it.ctl[3]);
    ft = frameTicks(it.ctl);
    rxData = '0; rxPar = 1'b0; startBit = 1'b1; stopAll = 1'b1;
    for (int rel = 1; rel < ft; rel++) begin
      nextTick();
      bitNo = rel / 16;
      if (bitNo >= 1 + len + par) stopAll &= txOut;
      else if (rel % 16 == 8) begin
        if (bitNo == 0)         startBit = txOut;
        else if (bitNo <= len)  rxData[bitNo-1] = txOut;
        else                    rxPar = txOut;
      end
    end
    expData = maskWord(it.data, it.ctl);
    expPar  = it.ctl[4] ? ^expData : ~^expData;
    check(rxData == expData, "R1 data bits", int'(rxData), int'(expData));
    check(!startBit && stopAll, "R8 start low and stop high",
          int'({startBit, stopAll}), 1);
    if (par == 1)
      check(rxPar == expPar, "R2 parity bit", int'(rxPar), int'(expPar));
  endtask

  initial begin : monitor
    logic prev;
    prev = 1'b1;
    forever begin
      nextTick();
      if (!rst) begin
        if (prev && !txOut) begin
          runFrame();
          prev = 1'b1;
        end else begin
          prev = txOut;
        end
      end
    end
  end

  // Driver: write a word and queue what the line must carry
  task automatic putWord(input logic [7:0] d, input logic [4:0] c);
    item_t it;
    @(negedge clk);
    wrData = d; lineCtl = c; wrEn = 1'b1;
    it.data = d; it.ctl = c;
    sbq.push_back(it);
    @(negedge clk);
    wrEn = 1'b0;
    check(holdEmpty == 1'b0, "R3 holdEmpty after write", int'(holdEmpty), 0);
  endtask

  task automatic waitEvt(output int idx);
    do @(negedge clk); while (!emptyEvt);
    idx = tickIdx;
    check(holdEmpty && !shiftEmpty && !txOut, "R4 handoff flags",
          int'({holdEmpty, shiftEmpty, txOut}), 4);
  endtask

  task automatic single(input logic [7:0] d, input logic [4:0] c);
    int e0, e1;
    putWord(d, c);
    waitEvt(e0);
    @(negedge clk);
    lineCtl = ~c;  // R9: late change must not affect this frame
    check(emptyEvt == 1'b0, "R4 event one cycle", int'(emptyEvt), 0);
    do @(negedge clk); while (!shiftEmpty);
    e1 = tickIdx;
    check(e1 - e0 == frameTicks(c), "R6 R8 frame length to shiftEmpty",
          e1 - e0, frameTicks(c));
    check(txOut == 1'b1, "R6 line idle high", int'(txOut), 1);
  endtask

  task automatic backToBack(input logic [7:0] a, input logic [4:0] ca,
                            input logic [7:0] b, input logic [4:0] cb);
    int   e0, e1, e2;
    logic bad;
    putWord(a, ca);
    waitEvt(e0);
    putWord(b, cb);  // R9: changes lineCtl during frame a
    bad = 1'b0;
    do begin
      @(negedge clk);
      if (!emptyEvt && (holdEmpty || shiftEmpty)) bad = 1'b1;
    end while (!emptyEvt);
    e1 = tickIdx;
    check(!bad, "R5 flags held low while queued", int'(bad), 0);
    check(e1 - e0 == frameTicks(ca), "R5 R8 gapless handoff tick",
          e1 - e0, frameTicks(ca));
    check(holdEmpty && !shiftEmpty, "R5 handoff flags",
          int'({holdEmpty, shiftEmpty}), 2);
    do @(negedge clk); while (!shiftEmpty);
    e2 = tickIdx;
    check(e2 - e1 == frameTicks(cb), "R6 R8 second frame length",
          e2 - e1, frameTicks(cb));
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    check(1'b0, "watchdog expired", cycles, 100000);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(holdEmpty && shiftEmpty, "R7 flags in reset", int'({holdEmpty, shiftEmpty}), 3);
    check(txOut == 1'b1, "R7 line high in reset", int'(txOut), 1);
    check(emptyEvt == 1'b0, "R7 no event in reset", int'(emptyEvt), 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check(shiftEmpty && holdEmpty && txOut, "R6 idle after reset",
          int'({shiftEmpty, holdEmpty, txOut}), 7);

    single(8'hA5, 5'b00011);      // 8 bits, no parity, 1 stop
    single(8'hF3, 5'b11010);      // 7 bits, even parity, 1 stop
    single(8'hEE, 5'b01100);      // 5 bits, odd parity, 1.5 stop
    single(8'hC8, 5'b00111);      // 8 bits, 2 stop
    backToBack(8'h5A, 5'b00101, 8'hC3, 5'b00100);  // 6b 2stop, 5b 1.5stop
    backToBack(8'h81, 5'b11011, 8'h7E, 5'b01110);  // 8b even, 7b odd 2stop
    backToBack(8'h00, 5'b00000, 8'hFF, 5'b10001);  // 5b 1stop, 6b odd? no: parity off

    repeat (20) @(negedge clk);
    check(sbq.size() == 0, "R1 all frames seen", sbq.size(), 0);
    check(r10Bad == 0, "R10 line moves only on ticks", r10Bad, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule